// File: doc/BRIEF.md
# Memory Ordering Issue Arbiter

This block keeps a small window of memory operations in program order (loads, stores, atomic read-modify-writes and address-free fences) and decides each cycle which one may be handed to the memory port. The set of legal reorderings is chosen by a mode input. The modes are strict sequential ordering, store-to-load relaxation, store relaxation and fully relaxed ordering. In the relaxed modes the fences are the only source of order.

Dispatch writes operations in order through an enqueue port. Each operation carries an operand-ready flag, and a wake port can raise that flag later by tag. An operation whose operand is late never holds back a younger one that the mode lets pass it. The memory side takes one operation per accepted handshake and later returns a completion tag, which frees the entry. Fences use no memory cycle. They leave the window as soon as their condition holds.

Top module: `mo_arbiter`

## Requirements
- R1: With mode = 0 (sequential), no load (op 0), store (op 1) or atomic (op 2) is offered for issue while an older memory operation in the window is still unissued.
- R2: With mode = 1, the only reordering allowed is a load passing an older unissued store. Load-load, load-store and store-store pairs keep program order.
- R3: With mode = 2, a younger load or store may pass an older unissued store. No operation passes an older unissued load.
- R4: With mode = 3, loads and stores may pass older unissued loads and stores in any combination.
- R5: In every mode, an access never passes an older unissued store or atomic that has the same address.
- R6: A full fence (op 3) blocks every younger memory operation until every older memory operation has completed. It then leaves the window without issuing.
- R7: A store-store fence (op 4) blocks only younger stores and atomics, until older stores and atomics complete. A load fence (op 5) blocks only younger loads and atomics, until older loads and atomics complete.
- R8: A one-directional fence (op 6) blocks younger stores and atomics only until every older memory operation has issued. Completion is not awaited.
- R9: An atomic issues only once every older memory operation has completed. No younger memory operation issues until the atomic completes.
- R10: An entry whose operand is not ready is never offered for issue, and it blocks younger entries only where R1 to R9 require it. A wake carrying its tag makes it ready.
- R11: At most one operation is offered per cycle: the oldest one that is eligible. It stays offered while iss_ready is low, and it is marked issued when iss_valid and iss_ready are both high at a clock edge.
- R12: The window holds DEPTH entries (8 by default). enq_ready is low when the window is full. A completion frees its entry, and slots are reclaimed in program order.
- R13: After reset the window is empty, enq_ready is high and iss_valid is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mode | input | 2 | Ordering mode: 0 sequential, 1 store-load relaxed, 2 store relaxed, 3 fully relaxed |
| enq_valid | input | 1 | Enqueue request from dispatch |
| enq_ready | output | 1 | Window has a free slot |
| enq_op | input | 3 | Operation code (0 load, 1 store, 2 atomic, 3 full fence, 4 store-store fence, 5 load fence, 6 one-directional fence) |
| enq_addr | input | ADDR_W | Access address (ignored for fences) |
| enq_tag | input | TAG_W | Operation tag |
| enq_opnd_rdy | input | 1 | Operand already available at enqueue |
| wake_valid | input | 1 | Operand wake-up strobe |
| wake_tag | input | TAG_W | Tag whose operand became ready |
| iss_valid | output | 1 | An operation is offered to memory |
| iss_ready | input | 1 | Memory accepts the offered operation |
| iss_op | output | 3 | Offered operation code |
| iss_addr | output | ADDR_W | Offered address |
| iss_tag | output | TAG_W | Offered tag |
| cmp_valid | input | 1 | Completion strobe from memory |
| cmp_tag | input | TAG_W | Tag of the completed operation |

## Verification
The ordering rules are tried with two-entry programs in which the older entry waits on its operand and the younger one is ready. Whether the younger entry is offered shows which pair types each mode relaxes. The same programs with equal addresses separate address-based ordering from mode-based ordering. Three-entry programs put each fence kind between an unready access and a ready one, which separates the load-only fence, the store-only fences and the full fence. Issue-then-complete sequences tell a release on completion (full fence, atomic) from a release on issue (one-directional fence). They also check oldest-first choice, wake-up by tag and the full window.

// File: rtl/mo_pkg.sv
package mo_pkg;

    parameter int ADDR_W = 16;
    parameter int TAG_W  = 4;

    typedef enum logic [1:0] {
        MODE_SC  = 2'd0,
        MODE_TSO = 2'd1,
        MODE_PSO = 2'd2,
        MODE_WO  = 2'd3
    } mode_e;

    localparam logic [2:0] OP_LD    = 3'd0;
    localparam logic [2:0] OP_ST    = 3'd1;
    localparam logic [2:0] OP_ATOM  = 3'd2;
    localparam logic [2:0] OP_FFULL = 3'd3;
    localparam logic [2:0] OP_FSS   = 3'd4;
    localparam logic [2:0] OP_FLD   = 3'd5;
    localparam logic [2:0] OP_FST1  = 3'd6;

    typedef struct packed {
        logic              valid;
        logic              issued;
        logic              rdy;
        logic [2:0]        op;
        logic [ADDR_W-1:0] addr;
        logic [TAG_W-1:0]  tag;
    } entry_t;

    function automatic logic is_mem(input logic [2:0] op);
        return (op == OP_LD) || (op == OP_ST) || (op == OP_ATOM);
    endfunction

    function automatic logic is_fence(input logic [2:0] op);
        return (op == OP_FFULL) || (op == OP_FSS) || (op == OP_FLD) || (op == OP_FST1);
    endfunction

    function automatic logic writes_mem(input logic [2:0] op);
        return (op == OP_ST) || (op == OP_ATOM);
    endfunction

    function automatic logic reads_mem(input logic [2:0] op);
        return (op == OP_LD) || (op == OP_ATOM);
    endfunction

    // Does the mode keep an older/younger access pair in program order?
    function automatic logic pair_ordered(input mode_e m, input logic [2:0] o, input logic [2:0] y);
        logic r;
        if (o == OP_ATOM || y == OP_ATOM) begin
            r = 1'b1;
        end else begin
            case (m)
                MODE_SC:  r = 1'b1;
                MODE_TSO: r = !(o == OP_ST && y == OP_LD);
                MODE_PSO: r = (o == OP_LD);
                default:  r = 1'b0;
            endcase
        end
        return r;
    endfunction

    // Does a pending fence of kind f hold back a younger access y?
    function automatic logic fence_blocks(input logic [2:0] f, input logic [2:0] y);
        logic r;
        case (f)
            OP_FFULL: r = 1'b1;
            OP_FSS:   r = writes_mem(y);
            OP_FST1:  r = writes_mem(y);
            OP_FLD:   r = reads_mem(y);
            default:  r = 1'b0;
        endcase
        return r;
    endfunction

endpackage

// File: rtl/mo_order_rules.sv
module mo_order_rules
    import mo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  mode_e                         mode,
    input  logic [DEPTH-1:0]              in_win,
    input  logic [DEPTH-1:0]              w_valid,
    input  logic [DEPTH-1:0]              w_issued,
    input  logic [DEPTH-1:0]              w_rdy,
    input  logic [DEPTH-1:0][2:0]         w_op,
    input  logic [DEPTH-1:0][ADDR_W-1:0]  w_addr,
    output logic [DEPTH-1:0]              elig,
    output logic [DEPTH-1:0]              fence_ok
);

    // Position 0 is the oldest slot of the window; every position is
    // compared with all positions before it.
    for (genvar p = 0; p < DEPTH; p++) begin : g_pos
        logic blk;
        logic pend_any;
        logic pend_st;
        logic pend_ld;
        logic pend_uniss;

        always_comb begin
            blk        = 1'b0;
            pend_any   = 1'b0;
            pend_st    = 1'b0;
            pend_ld    = 1'b0;
            pend_uniss = 1'b0;
            for (int q = 0; q < p; q++) begin
                if (in_win[q] && w_valid[q]) begin
                    if (is_mem(w_op[q])) begin
                        pend_any = 1'b1;
                        if (writes_mem(w_op[q])) pend_st = 1'b1;
                        if (reads_mem(w_op[q]))  pend_ld = 1'b1;
                        if (!w_issued[q]) begin
                            pend_uniss = 1'b1;
                            if (pair_ordered(mode, w_op[q], w_op[p])) blk = 1'b1;
                            if (writes_mem(w_op[q]) && (w_addr[q] == w_addr[p])) blk = 1'b1;
                        end
                        if (w_op[q] == OP_ATOM) blk = 1'b1;
                        if (w_op[p] == OP_ATOM) blk = 1'b1;
                    end else if (fence_blocks(w_op[q], w_op[p])) begin
                        blk = 1'b1;
                    end
                end
            end
        end

        always_comb begin
            elig[p] = in_win[p] && w_valid[p] && !w_issued[p] && w_rdy[p]
                    && is_mem(w_op[p]) && !blk;
            case (w_op[p])
                OP_FFULL: fence_ok[p] = in_win[p] && w_valid[p] && !pend_any;
                OP_FSS:   fence_ok[p] = in_win[p] && w_valid[p] && !pend_st;
                OP_FLD:   fence_ok[p] = in_win[p] && w_valid[p] && !pend_ld;
                OP_FST1:  fence_ok[p] = in_win[p] && w_valid[p] && !pend_uniss;
                default:  fence_ok[p] = 1'b0;
            endcase
        end
    end

endmodule

// File: rtl/mo_pick.sv
module mo_pick #(
    parameter int N = 8
) (
    input  logic [N-1:0] req,
    output logic [N-1:0] gnt,
    output logic         any
);

    logic found;

    always_comb begin
        gnt   = '0;
        found = 1'b0;
        for (int i = 0; i < N; i++) begin
            if (req[i] && !found) begin
                gnt[i] = 1'b1;
                found  = 1'b1;
            end
        end
    end

    assign any = found;

endmodule

// File: rtl/mo_arbiter.sv
module mo_arbiter
    import mo_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        mode,
    input  logic              enq_valid,
    output logic              enq_ready,
    input  logic [2:0]        enq_op,
    input  logic [ADDR_W-1:0] enq_addr,
    input  logic [TAG_W-1:0]  enq_tag,
    input  logic              enq_opnd_rdy,
    input  logic              wake_valid,
    input  logic [TAG_W-1:0]  wake_tag,
    output logic              iss_valid,
    input  logic              iss_ready,
    output logic [2:0]        iss_op,
    output logic [ADDR_W-1:0] iss_addr,
    output logic [TAG_W-1:0]  iss_tag,
    input  logic              cmp_valid,
    input  logic [TAG_W-1:0]  cmp_tag
);

    // DEPTH must be a power of two so that the pointers wrap naturally.
    localparam int PW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
    localparam int CW = $clog2(DEPTH + 1);

    typedef struct packed {
        entry_t [DEPTH-1:0] ent;
        logic   [PW-1:0]    head;
        logic   [PW-1:0]    tail;
        logic   [CW-1:0]    count;
    } state_t;

    state_t s_q, s_d;
    mode_e  mode_m;

    logic [DEPTH-1:0]             in_win, r_valid, r_issued, r_rdy;
    logic [DEPTH-1:0][2:0]        r_op;
    logic [DEPTH-1:0][ADDR_W-1:0] r_addr;
    logic [DEPTH-1:0][PW-1:0]     r_phys;
    logic [DEPTH-1:0]             elig, fence_ok, gnt;
    logic                         any;
    logic [PW-1:0]                sel;
    logic [CW-1:0]                occ;
    logic                         push, pop;

    assign mode_m = mode_e'(mode);
    assign occ    = s_q.count;

    // View of the window rotated so that position 0 is the oldest slot
    always_comb begin
        for (int p = 0; p < DEPTH; p++) begin
            r_phys[p]   = s_q.head + PW'(p);
            in_win[p]   = (CW'(p) < s_q.count);
            r_valid[p]  = s_q.ent[r_phys[p]].valid;
            r_issued[p] = s_q.ent[r_phys[p]].issued;
            r_rdy[p]    = s_q.ent[r_phys[p]].rdy;
            r_op[p]     = s_q.ent[r_phys[p]].op;
            r_addr[p]   = s_q.ent[r_phys[p]].addr;
        end
    end

    mo_order_rules #(.DEPTH(DEPTH)) u_rules (
        .mode     (mode_m),
        .in_win   (in_win),
        .w_valid  (r_valid),
        .w_issued (r_issued),
        .w_rdy    (r_rdy),
        .w_op     (r_op),
        .w_addr   (r_addr),
        .elig     (elig),
        .fence_ok (fence_ok)
    );

    mo_pick #(.N(DEPTH)) u_pick (
        .req (elig),
        .gnt (gnt),
        .any (any)
    );

    always_comb begin
        sel = '0;
        for (int p = 0; p < DEPTH; p++) begin
            if (gnt[p]) sel = r_phys[p];
        end
    end

    assign iss_valid = any;
    assign iss_op    = s_q.ent[sel].op;
    assign iss_addr  = s_q.ent[sel].addr;
    assign iss_tag   = s_q.ent[sel].tag;
    assign enq_ready = (s_q.count < CW'(DEPTH));

    assign push = enq_valid && enq_ready;
    assign pop  = (s_q.count != '0) && !s_q.ent[s_q.head].valid;

    always_comb begin
        s_d = s_q;

        for (int i = 0; i < DEPTH; i++) begin
            if (wake_valid && s_q.ent[i].valid && (s_q.ent[i].tag == wake_tag))
                s_d.ent[i].rdy = 1'b1;
            if (cmp_valid && s_q.ent[i].valid && s_q.ent[i].issued
                && (s_q.ent[i].tag == cmp_tag))
                s_d.ent[i].valid = 1'b0;
        end

        if (any && iss_ready)
            s_d.ent[sel].issued = 1'b1;

        for (int p = 0; p < DEPTH; p++) begin
            if (fence_ok[p])
                s_d.ent[r_phys[p]].valid = 1'b0;
        end

        if (push) begin
            s_d.ent[s_q.tail].valid  = 1'b1;
            s_d.ent[s_q.tail].issued = 1'b0;
            s_d.ent[s_q.tail].rdy    = enq_opnd_rdy || is_fence(enq_op);
            s_d.ent[s_q.tail].op     = enq_op;
            s_d.ent[s_q.tail].addr   = enq_addr;
            s_d.ent[s_q.tail].tag    = enq_tag;
            s_d.tail                 = s_q.tail + PW'(1);
        end

        if (pop)
            s_d.head = s_q.head + PW'(1);

        s_d.count = s_q.count + CW'(push) - CW'(pop);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/mo_arbiter_chk.sv
module mo_arbiter_chk #(
    parameter int DEPTH = 8,
    parameter int CW    = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic [1:0]       mode,
    input logic             iss_valid,
    input logic [DEPTH-1:0] elig,
    input logic [DEPTH-1:0] gnt,
    input logic [CW-1:0]    occ
);

    // R11: a single offer per cycle
    a_r11_onehot_grant: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(gnt));

    // R11: the granted slot was judged eligible by the ordering rules
    a_r11_grant_eligible: assert property (@(posedge clk) disable iff (!rst_n)
        (gnt & ~elig) == '0);

    // R11: nothing eligible is older than the granted slot
    a_r11_oldest_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|gnt) |-> (((gnt - 1'b1) & elig) == '0));

    // R11: an offer exists exactly when some slot is eligible
    a_r11_offer_matches: assert property (@(posedge clk) disable iff (!rst_n)
        iss_valid == (|elig));

    // R12: occupancy never exceeds the capacity
    a_r12_occupancy_bound: assert property (@(posedge clk) disable iff (!rst_n)
        occ <= CW'(DEPTH));

    // R1: in sequential mode at most one slot can ever be eligible
    a_r1_sc_single: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == 2'd0) |-> ($countones(elig) <= 1));

endmodule

bind mo_arbiter mo_arbiter_chk #(.DEPTH(DEPTH)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .mode      (mode),
    .iss_valid (iss_valid),
    .elig      (elig),
    .gnt       (gnt),
    .occ       (occ)
);

// File: tb/mo_arbiter_bench.sv
`timescale 1ns/1ps
module mo_arbiter_bench;
    import mo_pkg::*;

    localparam logic [2:0] L = 3'd0, S = 3'd1, A = 3'd2, FF = 3'd3,
                           FSS = 3'd4, FLD = 3'd5, F1 = 3'd6, NO = 3'd7;
    localparam int NV = 22;

    // {req, mode, op0 (operand late), op1, op2, same_addr, exp_valid, exp_tag}
    localparam logic [18:0] VEC [NV] = '{
        {4'd1,  2'd0, L, L,   NO, 1'b0, 1'b0, 2'd0},  // R1
        {4'd1,  2'd0, S, L,   NO, 1'b0, 1'b0, 2'd0},  // R1
        {4'd2,  2'd1, S, L,   NO, 1'b0, 1'b1, 2'd1},  // R2
        {4'd2,  2'd1, L, L,   NO, 1'b0, 1'b0, 2'd0},  // R2
        {4'd2,  2'd1, S, S,   NO, 1'b0, 1'b0, 2'd0},  // R2
        {4'd3,  2'd2, S, S,   NO, 1'b0, 1'b1, 2'd1},  // R3
        {4'd3,  2'd2, S, L,   NO, 1'b0, 1'b1, 2'd1},  // R3
        {4'd3,  2'd2, L, S,   NO, 1'b0, 1'b0, 2'd0},  // R3
        {4'd4,  2'd3, L, L,   NO, 1'b0, 1'b1, 2'd1},  // R4
        {4'd4,  2'd3, L, S,   NO, 1'b0, 1'b1, 2'd1},  // R4
        {4'd5,  2'd3, S, L,   NO, 1'b1, 1'b0, 2'd0},  // R5
        {4'd5,  2'd2, S, S,   NO, 1'b1, 1'b0, 2'd0},  // R5
        {4'd6,  2'd3, L, FF,  L,  1'b0, 1'b0, 2'd0},  // R6
        {4'd6,  2'd1, S, FF,  L,  1'b0, 1'b0, 2'd0},  // R6
        {4'd7,  2'd3, S, FSS, L,  1'b0, 1'b1, 2'd2},  // R7
        {4'd7,  2'd3, S, FSS, S,  1'b0, 1'b0, 2'd0},  // R7
        {4'd7,  2'd3, L, FLD, L,  1'b0, 1'b0, 2'd0},  // R7
        {4'd7,  2'd3, S, FLD, S,  1'b0, 1'b1, 2'd2},  // R7
        {4'd8,  2'd3, L, F1,  S,  1'b0, 1'b0, 2'd0},  // R8
        {4'd8,  2'd3, L, F1,  L,  1'b0, 1'b1, 2'd2},  // R8
        {4'd9,  2'd3, L, A,   NO, 1'b0, 1'b0, 2'd0},  // R9
        {4'd9,  2'd3, A, L,   NO, 1'b0, 1'b0, 2'd0}   // R9
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [1:0]        mode = 2'd0;
    logic              enq_valid = 1'b0;
    logic              enq_ready;
    logic [2:0]        enq_op = 3'd0;
    logic [ADDR_W-1:0] enq_addr = '0;
    logic [TAG_W-1:0]  enq_tag = '0;
    logic              enq_opnd_rdy = 1'b0;
    logic              wake_valid = 1'b0;
    logic [TAG_W-1:0]  wake_tag = '0;
    logic              iss_valid;
    logic              iss_ready = 1'b0;
    logic [2:0]        iss_op;
    logic [ADDR_W-1:0] iss_addr;
    logic [TAG_W-1:0]  iss_tag;
    logic              cmp_valid = 1'b0;
    logic [TAG_W-1:0]  cmp_tag = '0;

    int n_tests = 0;
    int n_fail  = 0;

    always #10 clk = ~clk;

    mo_arbiter u_mo_arbiter (
        .clk, .rst_n, .mode, .enq_valid, .enq_ready, .enq_op, .enq_addr,
        .enq_tag, .enq_opnd_rdy, .wake_valid, .wake_tag, .iss_valid,
        .iss_ready, .iss_op, .iss_addr, .iss_tag, .cmp_valid, .cmp_tag
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Offer check: exp_v = 0 means nothing offered, else tag exp_t offered
    task automatic chk_offer(input string req, input bit exp_v, input int exp_t);
        if (exp_v) chk(iss_valid && (int'(iss_tag) == exp_t), req,
                       iss_valid ? int'(iss_tag) : -1, exp_t);
        else       chk(!iss_valid, req, iss_valid ? int'(iss_tag) : -1, -1);
    endtask

    task automatic do_reset(input logic [1:0] m);
        rst_n = 1'b0; mode = m; enq_valid = 1'b0; wake_valid = 1'b0;
        iss_ready = 1'b0; cmp_valid = 1'b0;
        @(negedge clk); @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic push(input logic [2:0] op, input logic [ADDR_W-1:0] a,
                        input logic [TAG_W-1:0] t, input logic r);
        enq_valid = 1'b1; enq_op = op; enq_addr = a; enq_tag = t; enq_opnd_rdy = r;
        @(negedge clk);
        enq_valid = 1'b0;
    endtask

    task automatic pulse_issue;
        iss_ready = 1'b1; @(negedge clk); iss_ready = 1'b0;
    endtask

    task automatic complete(input logic [TAG_W-1:0] t);
        cmp_valid = 1'b1; cmp_tag = t; @(negedge clk); cmp_valid = 1'b0;
    endtask

    task automatic wake(input logic [TAG_W-1:0] t);
        wake_valid = 1'b1; wake_tag = t; @(negedge clk); wake_valid = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_tests++; n_fail++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        // R13: reset state
        do_reset(2'd3);
        chk(enq_ready == 1'b1, "R13", int'(enq_ready), 1);
        chk(iss_valid == 1'b0, "R13", int'(iss_valid), 0);

        // Ordering table: oldest entry waits on its operand, later ones are ready
        for (int v = 0; v < NV; v++) begin
            logic [2:0] ops [3];
            string rq;
            ops[0] = VEC[v][12:10]; ops[1] = VEC[v][9:7]; ops[2] = VEC[v][6:4];
            rq = $sformatf("R%0d vec%0d", VEC[v][18:15], v);
            do_reset(VEC[v][14:13]);
            for (int k = 0; k < 3; k++) begin
                if (ops[k] != NO)
                    push(ops[k], VEC[v][3] ? ADDR_W'('h40) : ADDR_W'((k + 1) * 'h100),
                         TAG_W'(k), (k != 0));
            end
            chk_offer(rq, VEC[v][2], int'(VEC[v][1:0]));
        end

        // R10, R11: wake-up and oldest-first choice
        do_reset(2'd3);
        push(L, 'h100, 0, 1'b0);
        push(L, 'h200, 1, 1'b1);
        push(L, 'h300, 2, 1'b1);
        chk_offer("R10", 1'b1, 1);
        wake(0);
        chk_offer("R11", 1'b1, 0);
        @(negedge clk);
        chk_offer("R11", 1'b1, 0);   // held while iss_ready is low
        pulse_issue();
        chk_offer("R11", 1'b1, 1);

        // R12: full window, then free the oldest slot
        do_reset(2'd3);
        for (int k = 0; k < 8; k++) push(L, ADDR_W'(k * 'h10), TAG_W'(k), 1'b1);
        chk(enq_ready == 1'b0, "R12", int'(enq_ready), 0);
        pulse_issue();
        complete(0);
        @(negedge clk);
        chk(enq_ready == 1'b1, "R12", int'(enq_ready), 1);

        // R6: full fence waits for completion of the older store
        do_reset(2'd3);
        push(S, 'h100, 0, 1'b1);
        push(FF, 'h0, 1, 1'b1);
        push(L, 'h200, 2, 1'b1);
        chk_offer("R6", 1'b1, 0);
        pulse_issue();
        chk_offer("R6", 1'b0, 0);
        complete(0);
        @(negedge clk);
        chk_offer("R6", 1'b1, 2);

        // R9: atomic holds back a younger load until it completes
        do_reset(2'd3);
        push(A, 'h100, 0, 1'b1);
        push(L, 'h200, 1, 1'b1);
        chk_offer("R9", 1'b1, 0);
        pulse_issue();
        chk_offer("R9", 1'b0, 0);
        complete(0);
        chk_offer("R9", 1'b1, 1);

        // R8: one-directional fence releases on issue, not completion
        do_reset(2'd3);
        push(L, 'h100, 0, 1'b1);
        push(F1, 'h0, 1, 1'b1);
        push(S, 'h200, 2, 1'b1);
        chk_offer("R8", 1'b1, 0);
        pulse_issue();
        @(negedge clk);
        chk_offer("R8", 1'b1, 2);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule